// File: doc/BRIEF.md
# Synchronous serial port with write-collision detection

This block is a byte-wide synchronous serial port that runs either as the clock-driving master or as a clocked slave. On the host side, writing the data register loads the outgoing byte into a shift register. In master mode, a write made while the port is idle also starts a transfer. Bits leave and enter most significant first. After the eighth bit, the received byte moves into a receive buffer register, and the buffer-full and interrupt flags rise together. That buffer is separate from the shift register, so the next byte can shift while the last one waits to be read.

The serial clock idles at the level chosen by the polarity bit. The edge bit picks which half of each bit time holds the clock away from idle, and so whether data changes on the leading or the trailing clock edge. In master mode, input can be sampled either in the middle of the output bit or at its end. The master clock runs at the system clock divided by 4, 16 or 64.

A host write that arrives during a transfer is dropped and sets a sticky collision flag. A byte that completes while the buffer is still full is dropped and sets a sticky overflow flag. In slave mode the select input can be enabled: the port then shifts only while select is low, and drives its output only while select is low. Clearing the enable input returns the whole port to idle.

Top module: `spi_port`

## Requirements
- R1: After reset with enable low, buf_full, irq, wcol and ovf are 0, and sck_oe and sdo_oe are 0.
- R2: In master mode, a write while idle sends the byte most significant bit first. The bit on sdo is stable at the mid-bit clock edge.
- R3: A master transfer makes exactly 16 transitions on sck_o and then leaves it at the cpol level. With cke=0 the clock is away from idle in the second half of each bit time; with cke=1 it is away from idle in the first half.
- R4: A master byte takes 16*H system cycles from the write edge to buf_full. H is 2, 8 or 32 for rate 0, 1 and 2-or-3 respectively.
- R5: With smp_end=0 the master samples sdi at the mid-bit edge. With smp_end=1 it samples sdi at the end of each bit time.
- R6: On completion, the received byte appears on rd_data and buf_full and irq rise in the same cycle. A host read clears buf_full, and irq_clr clears irq.
- R7: A write while idle is accepted even when buf_full is set: no collision is flagged and the byte is transmitted.
- R8: A byte that completes while buf_full is set, with no read in that cycle, is discarded. The old byte stays on rd_data, and ovf is set and stays set until ovf_clr.
- R9: A write during a transfer is ignored (the transfer keeps its original byte). It sets wcol, which stays set until wcol_clr.
- R10: When a host read and a byte completion fall in the same cycle, the new byte is stored, buf_full stays 1 and ovf is not set.
- R11: In slave mode the port shifts on the external sck_i according to cpol and cke. It transmits the loaded byte and receives a byte, both most significant bit first.
- R12: In slave mode with ss_en=1, sdo_oe is 0 and clock edges are ignored while ss_n is high. If ss_n goes high in the middle of a byte, the byte is aborted and the bit count restarts.
- R13: Driving enable low clears buf_full, irq, wcol and ovf. Writes made while enable is low start no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Port enable; low holds the port idle and clears its flags |
| master | input | 1 | 1 = master, 0 = slave |
| cpol | input | 1 | Idle level of the serial clock |
| cke | input | 1 | 0 = data changes on the trailing edge, 1 = on the leading edge |
| smp_end | input | 1 | Master only: sample input at the end of the bit time |
| ss_en | input | 1 | Slave only: honour ss_n |
| rate | input | 2 | Master clock divider select |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | W | Byte to transmit |
| rd_en | input | 1 | Host read strobe; clears buf_full |
| rd_data | output | W | Receive buffer |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| irq | output | 1 | Byte-complete interrupt flag |
| wcol | output | 1 | Sticky write-collision flag |
| ovf | output | 1 | Sticky receive-overflow flag |
| irq_clr | input | 1 | Clears irq |
| wcol_clr | input | 1 | Clears wcol |
| ovf_clr | input | 1 | Clears ovf |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| ss_n | input | 1 | Slave select, active low |

## Verification
Two events can fall on the same clock edge: the host emptying the receive buffer, and a new byte completing into it. To provoke this, the bench leaves one byte unread, starts a second master transfer, and raises rd_en exactly 16*H cycles after the write edge. That cycle is computed from the divider setting, not read from the design. The result passes if buf_full stays set, rd_data shows the second byte and ovf stays clear. The same sequence run without the read must instead keep the first byte and raise ovf.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         master,
  input  logic         cpol,
  input  logic         cke,
  input  logic         smp_end,
  input  logic         ss_en,
  input  logic [1:0]   rate,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         buf_full,
  output logic         irq,
  output logic         wcol,
  output logic         ovf,
  input  logic         irq_clr,
  input  logic         wcol_clr,
  input  logic         ovf_clr,
  output logic         sck_o,
  output logic         sck_oe,
  input  logic         sck_i,
  input  logic         sdi,
  output logic         sdo,
  output logic         sdo_oe,
  input  logic         ss_n
);
  localparam int CW = $clog2(W);
  localparam int DW = 5;
  localparam logic [DW-1:0] HL0 = DW'(1);
  localparam logic [DW-1:0] HL1 = DW'(7);
  localparam logic [DW-1:0] HL2 = DW'(31);
  localparam logic [CW-1:0] LASTB = CW'(W - 1);

  logic [2:0] sck_sy;
  logic [1:0] sdi_sy, ss_sy;
  logic [W-1:0] sr, bq;
  logic [CW-1:0] cnt;
  logic [DW-1:0] dcnt;
  logic busy, ph, pend, sbit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_sy <= '0;
      sdi_sy <= '0;
      ss_sy  <= '1;
    end else begin
      sck_sy <= {sck_sy[1:0], sck_i};
      sdi_sy <= {sdi_sy[0], sdi};
      ss_sy  <= {ss_sy[0], ss_n};
    end

  wire sck_s = sck_sy[1];
  wire sdi_s = sdi_sy[1];
  wire ss_s  = ss_sy[1];
  wire s_edge = sck_s != sck_sy[2];
  wire lead   = s_edge && (sck_s != cpol);
  wire trail  = s_edge && (sck_s == cpol);
  wire samp_e = cke ? trail : lead;
  wire chg_e  = cke ? lead : trail;

  wire sl_act   = !ss_en || !ss_s;
  wire sl_abort = ss_en && ss_s && busy;

  wire [DW-1:0] hlim = (rate == 2'd0) ? HL0 : (rate == 2'd1) ? HL1 : HL2;
  wire tick   = busy && (dcnt == hlim);
  wire mbit   = smp_end ? sdi : sbit;
  wire m_last = master && tick && ph && (cnt == LASTB);
  wire s_samp = !master && sl_act && samp_e && !sl_abort;
  wire s_last = s_samp && (cnt == LASTB);
  wire last   = master ? m_last : s_last;
  wire done   = enable && last;
  wire [W-1:0] rx_byte = {sr[W-2:0], master ? mbit : sdi_s};
  wire wr_ok  = enable && wr_en && !busy;
  wire wr_col = enable && wr_en && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0; bq <= '0; cnt <= '0; dcnt <= '0;
      busy <= 1'b0; ph <= 1'b0; pend <= 1'b0; sbit <= 1'b0;
      buf_full <= 1'b0; irq <= 1'b0; wcol <= 1'b0; ovf <= 1'b0;
    end else if (!enable) begin
      cnt <= '0; dcnt <= '0;
      busy <= 1'b0; ph <= 1'b0; pend <= 1'b0;
      buf_full <= 1'b0; irq <= 1'b0; wcol <= 1'b0; ovf <= 1'b0;
    end else begin
      if (wcol_clr) wcol <= 1'b0;
      if (wr_col) wcol <= 1'b1;
      if (irq_clr) irq <= 1'b0;
      if (ovf_clr) ovf <= 1'b0;
      if (rd_en) buf_full <= 1'b0;
      if (done) begin
        irq <= 1'b1;
        if (buf_full && !rd_en) ovf <= 1'b1;
        else begin
          bq <= rx_byte;
          buf_full <= 1'b1;
        end
      end
      if (master) begin
        if (wr_ok) begin
          sr <= wr_data; busy <= 1'b1; cnt <= '0; ph <= 1'b0; dcnt <= '0;
        end else if (busy) begin
          dcnt <= tick ? '0 : dcnt + 1'b1;
          if (tick) begin
            ph <= ~ph;
            if (!ph) sbit <= sdi;
            else begin
              sr  <= rx_byte;
              cnt <= cnt + 1'b1;
              if (last) begin
                busy <= 1'b0;
                cnt  <= '0;
              end
            end
          end
        end
      end else begin
        if (wr_ok) sr <= wr_data;
        if (sl_abort) begin
          busy <= 1'b0; cnt <= '0; pend <= 1'b0;
        end else if (sl_act) begin
          if (s_samp) begin
            sbit <= sdi_s; busy <= 1'b1; pend <= 1'b1; cnt <= cnt + 1'b1;
            if (last) begin
              busy <= 1'b0; cnt <= '0; pend <= 1'b0;
            end
          end
          if (chg_e) begin
            if (cke) busy <= 1'b1;
            if (pend) begin
              sr   <= {sr[W-2:0], sbit};
              pend <= 1'b0;
            end
          end
        end
      end
    end
  end

  assign rd_data = bq;
  assign sdo     = sr[W-1];
  assign sdo_oe  = enable && (master || sl_act);
  assign sck_oe  = enable && master;
  assign sck_o   = (master && busy) ? (cpol ^ (cke ? ~ph : ph)) : cpol;
endmodule

module spi_port_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic wr_en,
  input logic rd_en,
  input logic busy,
  input logic done,
  input logic buf_full,
  input logic irq,
  input logic wcol,
  input logic ovf,
  input logic wcol_clr,
  input logic ovf_clr
);
  assert_full_with_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full) |-> irq);
  assert_collision_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wr_en && busy) |=> wcol);
  assert_wcol_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wcol && !wcol_clr) |=> wcol);
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && ovf && !ovf_clr) |=> ovf);
  assert_read_meets_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_en && !ovf_clr) |=> (buf_full && $stable(ovf)));
  assert_disable_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!buf_full && !irq && !wcol && !ovf));
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .rd_en(rd_en),
  .busy(busy), .done(done), .buf_full(buf_full), .irq(irq), .wcol(wcol),
  .ovf(ovf), .wcol_clr(wcol_clr), .ovf_clr(ovf_clr)
);

// File: tb/spi_port_tb.sv
module spi_port_tb;
  localparam int TCLK = 10;

  logic clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  logic rst_n = 1'b0, enable = 1'b0, master = 1'b0, cpol = 1'b0, cke = 1'b0;
  logic smp_end = 1'b0, ss_en = 1'b0;
  logic [1:0] rate = 2'd0;
  logic wr_en = 1'b0, rd_en = 1'b0, irq_clr = 1'b0, wcol_clr = 1'b0, ovf_clr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic buf_full, irq, wcol, ovf, sck_o, sck_oe, sdo, sdo_oe;
  logic sck_i = 1'b0, sdi = 1'b0, ss_n = 1'b0;

  spi_port #(.W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .master(master), .cpol(cpol),
    .cke(cke), .smp_end(smp_end), .ss_en(ss_en), .rate(rate), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .buf_full(buf_full),
    .irq(irq), .wcol(wcol), .ovf(ovf), .irq_clr(irq_clr), .wcol_clr(wcol_clr),
    .ovf_clr(ovf_clr), .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .ss_n(ss_n)
  );

  int checks = 0;
  int fails = 0;

  task automatic chk_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setcfg(input bit m, input bit cp, input bit ck, input bit se,
                        input logic [1:0] rt, input bit sse);
    @(negedge clk);
    enable = 1'b0; master = m; cpol = cp; cke = ck; smp_end = se; rate = rt;
    ss_en = sse; sck_i = cp;
    wait_n(4);
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic host_read();
    rd_en = 1'b1; irq_clr = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic m_xfer(input logic [7:0] tx, input logic [7:0] q, input int half,
                        input int col_at, input bit rd_last,
                        output logic [7:0] seen, output int edges, output int first);
    logic prev;
    int m;
    bit f0;
    f0 = buf_full; seen = 8'h00; edges = 0; first = 0; m = 0;
    sdi = q[7]; prev = sck_o;
    for (int n = 0; n <= 16*half + 2; n++) begin
      wr_en = (n == 0) || (n == col_at);
      wr_data = (n == 0) ? tx : ~tx;
      rd_en = rd_last && (n == 16*half);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      if (!f0 && buf_full && first == 0) first = n;
      if (sck_o != prev) begin
        edges++;
        if (sck_o == (cpol ^ ~cke)) begin
          seen = {seen[6:0], sdo};
          m++;
          sdi = (m < 8) ? q[7-m] : 1'b0;
        end
        prev = sck_o;
      end
    end
  endtask

  task automatic s_xfer(input logic [7:0] tx, input logic [7:0] pat, input int nb,
                        output logic [7:0] got);
    @(negedge clk);
    wr_data = tx; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; got = 8'h00;
    for (int b = 0; b < nb; b++) begin
      if (!cke) begin
        sdi = pat[7-b]; wait_n(8);
        got = {got[6:0], sdo};
        sck_i = ~cpol; wait_n(8);
        sck_i = cpol;
      end else begin
        sck_i = ~cpol; sdi = pat[7-b]; wait_n(8);
        got = {got[6:0], sdo};
        sck_i = cpol; wait_n(8);
      end
    end
    wait_n(8);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] seen, q, expv, got, tx, pat;
    int edges, first, half;

    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 flags after reset", {buf_full, irq, wcol, ovf}, 0);
    chk_eq("R1 output enables after reset", {sck_oe, sdo_oe}, 0);

    for (int md = 0; md < 8; md++) begin
      setcfg(1'b1, md[0], md[1], md[2], 2'd0, 1'b0);
      for (int b = 0; b < 256; b++) begin
        tx = b[7:0];
        q = tx ^ 8'h5A;
        expv = md[2] ? {q[6:0], 1'b0} : q;
        m_xfer(tx, q, 2, -1, 1'b0, seen, edges, first);
        chk_eq("R4 byte time at rate 0", first, 32);
        chk_eq("R2 msb-first output", seen, tx);
        chk_eq("R3 sck transitions", edges, 16);
        chk_eq("R3 sck idle level", sck_o, cpol);
        chk_eq("R5 received byte for sample point", rd_data, expv);
        chk_eq("R6 irq with buffer full", {irq, buf_full}, 3);
        host_read();
        chk_eq("R6 read clears full", {irq, buf_full}, 0);
      end
    end

    for (int rt = 1; rt < 4; rt++) begin
      half = (rt == 1) ? 8 : 32;
      setcfg(1'b1, 1'b0, 1'b0, 1'b0, rt[1:0], 1'b0);
      m_xfer(8'hC3, 8'h3C, half, -1, 1'b0, seen, edges, first);
      chk_eq("R4 byte time for divider", first, 16*half);
      chk_eq("R4 received byte", rd_data, 8'h3C);
      host_read();
    end

    setcfg(1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
    m_xfer(8'h81, 8'h81, 2, -1, 1'b0, seen, edges, first);
    m_xfer(8'h42, 8'h42, 2, -1, 1'b0, seen, edges, first);
    chk_eq("R7 write while full accepted", wcol, 0);
    chk_eq("R7 byte sent while full", seen, 8'h42);
    chk_eq("R8 overflow raised", ovf, 1);
    chk_eq("R8 old byte kept", rd_data, 8'h81);
    wait_n(10);
    chk_eq("R8 overflow sticky", ovf, 1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk_eq("R8 overflow cleared", ovf, 0);

    m_xfer(8'h24, 8'h24, 2, -1, 1'b1, seen, edges, first);
    chk_eq("R10 full stays set", buf_full, 1);
    chk_eq("R10 new byte stored", rd_data, 8'h24);
    chk_eq("R10 no overflow", ovf, 0);
    host_read();

    m_xfer(8'hA5, 8'hA5, 2, 10, 1'b0, seen, edges, first);
    chk_eq("R9 collision flagged", wcol, 1);
    chk_eq("R9 transfer kept original", seen, 8'hA5);
    chk_eq("R9 received original", rd_data, 8'hA5);
    host_read();
    wait_n(10);
    chk_eq("R9 collision sticky", wcol, 1);
    wcol_clr = 1'b1; @(negedge clk); wcol_clr = 1'b0;
    chk_eq("R9 collision cleared", wcol, 0);

    for (int md = 0; md < 4; md++) begin
      setcfg(1'b0, md[0], md[1], 1'b0, 2'd0, 1'b0);
      for (int b = 0; b < 16; b++) begin
        tx = 8'(b * 37 + 11);
        pat = 8'(b * 53 + 5);
        s_xfer(tx, pat, 8, got);
        chk_eq("R11 slave transmit", got, tx);
        chk_eq("R11 slave receive", rd_data, pat);
        chk_eq("R11 slave full", buf_full, 1);
        host_read();
      end
    end

    setcfg(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1);
    ss_n = 1'b1; wait_n(8);
    chk_eq("R12 output off when deselected", sdo_oe, 0);
    s_xfer(8'h11, 8'h99, 8, got);
    chk_eq("R12 clocks ignored when deselected", buf_full, 0);
    ss_n = 1'b0; wait_n(8);
    chk_eq("R12 output on when selected", sdo_oe, 1);
    s_xfer(8'h3C, 8'hF0, 4, got);
    ss_n = 1'b1; wait_n(8);
    chk_eq("R12 abort leaves buffer empty", {sdo_oe, buf_full}, 0);
    ss_n = 1'b0; wait_n(8);
    s_xfer(8'h5A, 8'h6B, 8, got);
    chk_eq("R12 fresh byte after abort rx", rd_data, 8'h6B);
    chk_eq("R12 fresh byte after abort tx", got, 8'h5A);
    host_read();

    setcfg(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    m_xfer(8'h0F, 8'h0F, 2, 10, 1'b0, seen, edges, first);
    chk_eq("R13 flags set before disable", {buf_full, irq, wcol}, 7);
    enable = 1'b0; @(negedge clk);
    chk_eq("R13 disable clears flags", {buf_full, irq, wcol, ovf}, 0);
    wr_data = 8'hFF; wr_en = 1'b1; @(negedge clk); wr_en = 1'b0;
    edges = 0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (sck_o != cpol) edges++;
    end
    enable = 1'b1;
    wait_n(40);
    chk_eq("R13 write while disabled starts nothing", edges, 0);
    chk_eq("R13 no byte after re-enable", buf_full, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule